// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bit Array

This block models the register side of a microcontroller port whose pins need no direction register. Every bit holds an output latch written from an internal bus. A latch bit of 0 pulls its pin strongly low. A latch bit of 1 lets go of the pin and leaves it on a weak pullup. An external device can then pull the pin low, so the bit also works as an input. The block does not model pad analog behaviour. It emits three per-bit drive-control vectors (strong pull-down, weak pullup, strong pullup) and takes the resolved pad level back as an input.

A port-wide pullup selector picks one of three styles: no pullup (open-drain), weak pullup only, or weak pullup with a short strong-pullup burst that speeds up each 0-to-1 edge. A separate address-bus mode drives the pins actively high and low from a bus value, as a multiplexed external address/data bus needs. Software reads back two things: the latch contents, and the pin level after a two-flop synchronizer.

Top module: `qbio_port`

## Requirements
- R1: After reset every latch bit is 1. `rd_latch` reads all ones, `pd_en` is all zeros and `spu_en` is all zeros.
- R2: A cycle with `wr_en` high loads `wr_data` into the latch at that clock edge. `rd_latch` returns the latch contents from the following cycle on.
- R3: Outside address-bus mode, a latch bit of 0 sets its `pd_en` bit and clears its `wpu_en` and `spu_en` bits.
- R4: Outside address-bus mode, a latch bit of 1 clears `pd_en`. Its `wpu_en` bit is 1 for `pull_sel` 01, 10 and 11, and 0 for `pull_sel` 00.
- R5: With `pull_sel` 10 or 11 and address-bus mode off, a write that changes a latch bit from 0 to 1 raises that bit's `spu_en` for exactly BOOST_CYCLES cycles (default 1), starting in the cycle right after the write edge. Rewriting a 1 over a 1 gives no pulse. With `pull_sel` 00 or 01, `spu_en` stays 0 in GPIO operation.
- R6: `rd_pin` equals `pin_in` as it stood two clock edges earlier. It follows the pin, not the latch: a latch of 1 with the pin held low reads 0.
- R7: While `bus_mode` is high, every bit has `pd_en` = ~`bus_out`, `spu_en` = `bus_out` and `wpu_en` = 0, whatever the latch and `pull_sel` are. Writes still update the latch, and the latch value applies again once `bus_mode` falls.
- R8: For no bit and in no cycle are `pd_en` and either pullup enable asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | W | Data to load into the latch |
| pull_sel | input | 2 | Pullup style: 00 none, 01 weak, 10/11 weak plus strong burst |
| bus_mode | input | 1 | Address/data bus mode with active push-pull drive |
| bus_out | input | W | Value driven in bus mode |
| pin_in | input | W | Resolved pad level |
| rd_latch | output | W | Latch read path |
| rd_pin | output | W | Synchronized pin read path |
| pd_en | output | W | Strong pull-down enable |
| wpu_en | output | W | Weak pullup enable |
| spu_en | output | W | Strong pullup enable |

## Verification
The bench targets the strong-pullup burst. It checks that the burst lasts exactly one cycle after a 0-to-1 write. A design that held the burst on, or fired it on a 1-to-1 rewrite, would drive a released input pin hard high and fight any external device pulling it low. The bench also checks that the read-pin path shows the pin after two edges. A design that returned the latch there would report 1 for a pin held low. Bus mode is checked for drive taken from the bus value, for a latch left intact and for no leftover burst. A design that mixed in latch state would corrupt bus cycles or drive high and low at once.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

  typedef enum logic [1:0] {
    PULL_NONE  = 2'b00,
    PULL_WEAK  = 2'b01,
    PULL_BURST = 2'b10,
    PULL_BURSTX = 2'b11
  } pull_e;

  function automatic logic style_has_weak(input logic [1:0] sel);
    return sel != PULL_NONE;
  endfunction

  function automatic logic style_has_burst(input logic [1:0] sel);
    return sel[1];
  endfunction

  function automatic logic bit_rises(input logic old_v, input logic new_v);
    return ~old_v & new_v;
  endfunction

endpackage

// File: rtl/qbio_latch.sv
module qbio_latch #(
  parameter int W = 8,
  parameter int BOOST_CYCLES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] rise_evt,
  output logic [W-1:0] burst_act
);
  import qbio_pkg::*;

  localparam int CW = (BOOST_CYCLES < 2) ? 1 : $clog2(BOOST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BOOST_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n)     latch_q <= '1;
    else if (wr_en) latch_q <= wr_data;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt;
    assign rise_evt[i] = wr_en & bit_rises(latch_q[i], wr_data[i]);
    always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= '0;
      else if (rise_evt[i])          cnt <= LOAD;
      else if (wr_en && !wr_data[i]) cnt <= '0;
      else if (cnt != '0)            cnt <= cnt - 1'b1;
    end
    assign burst_act[i] = (cnt != '0);
  end

endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '1;
      sync_out <= '1;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/qbio_drive.sv
module qbio_drive #(
  parameter int W = 8
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] burst_act,
  input  logic [1:0]   pull_sel,
  input  logic         bus_mode,
  input  logic [W-1:0] bus_out,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] wpu_en,
  output logic [W-1:0] spu_en
);
  import qbio_pkg::*;

  always_comb begin
    if (bus_mode) begin
      pd_en  = ~bus_out;
      spu_en = bus_out;
      wpu_en = '0;
    end else begin
      pd_en  = ~latch_q;
      wpu_en = style_has_weak(pull_sel) ? latch_q : '0;
      spu_en = style_has_burst(pull_sel) ? (latch_q & burst_act) : '0;
    end
  end

endmodule

// File: rtl/qbio_port.sv
module qbio_port #(
  parameter int W = 8,
  parameter int BOOST_CYCLES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   pull_sel,
  input  logic         bus_mode,
  input  logic [W-1:0] bus_out,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rd_latch,
  output logic [W-1:0] rd_pin,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] wpu_en,
  output logic [W-1:0] spu_en
);
  logic [W-1:0] latch_q;
  logic [W-1:0] rise_evt;
  logic [W-1:0] burst_act;

  qbio_latch #(.W(W), .BOOST_CYCLES(BOOST_CYCLES)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .latch_q(latch_q), .rise_evt(rise_evt), .burst_act(burst_act)
  );

  qbio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(rd_pin)
  );

  qbio_drive #(.W(W)) u_drive (
    .latch_q(latch_q), .burst_act(burst_act), .pull_sel(pull_sel),
    .bus_mode(bus_mode), .bus_out(bus_out),
    .pd_en(pd_en), .wpu_en(wpu_en), .spu_en(spu_en)
  );

  assign rd_latch = latch_q;

endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   pull_sel,
  input logic         bus_mode,
  input logic [W-1:0] bus_out,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] rd_latch,
  input logic [W-1:0] rd_pin,
  input logic [W-1:0] pd_en,
  input logic [W-1:0] wpu_en,
  input logic [W-1:0] spu_en,
  input logic [W-1:0] rise_evt
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R8
  excl_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en & (wpu_en | spu_en)) == '0);

  // R3
  low_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> (pd_en == ~rd_latch));

  // R5
  burst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && pull_sel[1] && !bus_mode && !$past(bus_mode))
      |-> ((spu_en & $past(rise_evt)) == $past(rise_evt)));

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> ((spu_en & ~rd_latch) == '0));

  // R4
  no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && pull_sel == 2'b00) |-> (wpu_en == '0 && spu_en == '0));

  // R6
  pin_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (rd_pin == $past(pin_in, 2)));

  // R7
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (pd_en == ~bus_out && spu_en == bus_out && wpu_en == '0));

endmodule

bind qbio_port qbio_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pull_sel(pull_sel), .bus_mode(bus_mode),
  .bus_out(bus_out), .pin_in(pin_in), .rd_latch(rd_latch), .rd_pin(rd_pin),
  .pd_en(pd_en), .wpu_en(wpu_en), .spu_en(spu_en), .rise_evt(rise_evt)
);

// File: tb/sim_qbio_port.sv
module sim_qbio_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   pull_sel = 2'b01;
  logic         bus_mode = 1'b0;
  logic [W-1:0] bus_out = '0;
  logic [W-1:0] pin_in = '1;
  logic [W-1:0] rd_latch, rd_pin, pd_en, wpu_en, spu_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  qbio_port #(.W(W), .BOOST_CYCLES(1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pull_sel(pull_sel), .bus_mode(bus_mode), .bus_out(bus_out),
    .pin_in(pin_in), .rd_latch(rd_latch), .rd_pin(rd_pin),
    .pd_en(pd_en), .wpu_en(wpu_en), .spu_en(spu_en)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_excl();
    chk("R8 exclusion", pd_en & (wpu_en | spu_en), '0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write(input logic [W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 latch", rd_latch, '1);
    chk("R1 pd", pd_en, '0);
    chk("R1 spu", spu_en, '0);
    chk_excl();
  endtask

  task automatic t_write_read();
    pull_sel = 2'b01;
    write(8'h96);
    chk("R2 readback", rd_latch, 8'h96);
    chk("R3 pd", pd_en, 8'h69);
    chk("R4 weak", wpu_en, 8'h96);
    chk_excl();
    write(8'h3C);
    chk("R2 second write", rd_latch, 8'h3C);
  endtask

  task automatic t_styles();
    write(8'hF0);
    pull_sel = 2'b00;
    step();
    chk("R4 none weak", wpu_en, 8'h00);
    chk("R4 none pd", pd_en, 8'h0F);
    pull_sel = 2'b11;
    step();
    chk("R4 style11 weak", wpu_en, 8'hF0);
    chk_excl();
  endtask

  task automatic t_burst();
    pull_sel = 2'b10;
    write(8'h00);
    chk("R3 all low", pd_en, 8'hFF);
    write(8'h0F);
    chk("R5 burst on", spu_en, 8'h0F);
    chk("R5 weak too", wpu_en, 8'h0F);
    chk_excl();
    step();
    chk("R5 burst one cycle", spu_en, 8'h00);
    write(8'h0F);
    chk("R5 no burst on rewrite", spu_en, 8'h00);
    pull_sel = 2'b11;
    write(8'h3F);
    chk("R5 style11 burst", spu_en, 8'h30);
    step();
    chk("R5 style11 ends", spu_en, 8'h00);
    pull_sel = 2'b01;
    write(8'h00);
    write(8'hFF);
    chk("R5 weak style no burst", spu_en, 8'h00);
    pull_sel = 2'b00;
    write(8'h00);
    write(8'hFF);
    chk("R5 none style no burst", spu_en, 8'h00);
    chk("R4 none no weak", wpu_en, 8'h00);
  endtask

  task automatic t_pin();
    pull_sel = 2'b01;
    write(8'hFF);
    pin_in = 8'h5A;
    step();
    chk("R6 one edge old", rd_pin, 8'hFF);
    step();
    chk("R6 two edges new", rd_pin, 8'h5A);
    chk("R6 latch differs", rd_latch, 8'hFF);
    pin_in = 8'h00;
    step(); step();
    chk("R6 held low", rd_pin, 8'h00);
    pin_in = 8'hFF;
    step(); step();
  endtask

  task automatic t_bus();
    pull_sel = 2'b10;
    write(8'hFF);
    step();
    bus_mode = 1'b1;
    bus_out = 8'hA5;
    step();
    chk("R7 pd", pd_en, 8'h5A);
    chk("R7 spu", spu_en, 8'hA5);
    chk("R7 weak", wpu_en, 8'h00);
    chk_excl();
    write(8'h3C);
    chk("R7 latch written", rd_latch, 8'h3C);
    bus_out = 8'h0F;
    step();
    chk("R7 new bus value", spu_en, 8'h0F);
    bus_mode = 1'b0;
    step();
    chk("R7 back to latch pd", pd_en, 8'hC3);
    chk("R7 back to latch weak", wpu_en, 8'h3C);
    chk("R7 no stray burst", spu_en, 8'h00);
    chk_excl();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_write_read();
    t_styles();
    t_burst();
    t_pin();
    t_bus();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule